// File: doc/BRIEF.md
# Serial Control Register with Analog Path Decode

This block is the digital side of a voice front end's control port. A host writes one 8-bit configuration word over three wires: a frame enable, a shift clock and a data line. Bits are collected while the enable is low and become active together when the enable returns high. The active word is decoded into select and enable signals for the analog circuitry. These signals cover the transmit source (silence, input A, input B, or the sum of both with each input attenuated), the switching of the receive signal onto a differential driver and onto an auxiliary output, and a 3-bit receive volume code in 4 dB steps. The volume is also given as a whole number of decibels.

The three serial wires are asynchronous to the block clock. They pass through a synchronizer and are edge-detected in the clock domain. An active-low power-down input returns the active word to its defaults: input A selected, differential driver on, auxiliary output off, volume 0 dB. It also empties the shift holder. The defaults stay in place after power-down is released, until the host writes a new word.

Top module: `serial_path_ctl`

## Requirements
- R1: While `ser_en` is low, each rising edge of `ser_clk` shifts `ser_dat` into the holder, with bit 7 sent first. When more than 8 bits are shifted, the last 8 are the ones used.
- R2: Rising edges of `ser_clk` while `ser_en` is high have no effect on the holder or on any later committed word.
- R3: The outputs change only on a rising edge of `ser_en`. A committed word takes effect within SYNC_STAGES+2 clock cycles of that edge. Shifting alone leaves the outputs unchanged.
- R4: `tx_src` equals {bit 6, bit 7} of the word. The codes are 00 silence (both inputs off), 01 input A only, 10 input B only, and 11 both inputs. For code 11, `tx_halve` is high so that each input is reduced by about 6 dB.
- R5: `rx_drv_on` follows bit 5 and `rx_aux_on` follows bit 4. When a signal is low, its output holds signal ground. Bit 3 has no effect on any output.
- R6: `rx_vol` equals bits 2..0, with bit 2 as the MSB. `rx_gain_db` equals `rx_vol` times 4, which gives 0 to 28.
- R7: While `sleep_n` is low, the outputs take the default word 8'hA0 (`tx_src`=01, driver on, auxiliary off, volume 0) from the next clock onward. They keep the defaults after release until a new commit.
- R8: Power-down clears the holder. A commit made after fewer than 8 shifted bits has zeros in the bits that were not filled.
- R9: A power-down that coincides with a commit wins, and the defaults remain. A `ser_clk` rise seen in the same sample as a `ser_en` rise is not shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to sample the serial wires |
| sleep_n | input | 1 | Active-low power-down; forces defaults and clears the holder |
| ser_en | input | 1 | Frame enable: low while shifting, rising edge commits |
| ser_clk | input | 1 | Serial shift clock, rising edge active |
| ser_dat | input | 1 | Serial data, bit 7 first |
| tx_src | output | 2 | Transmit source code {bit6,bit7} |
| tx_a_on | output | 1 | Input A routed to the converter |
| tx_b_on | output | 1 | Input B routed to the converter |
| tx_halve | output | 1 | Both inputs summed, each attenuated ~6 dB |
| rx_drv_on | output | 1 | Differential driver carries the receive signal |
| rx_aux_on | output | 1 | Auxiliary output carries the converter signal |
| rx_vol | output | 3 | Receive volume code |
| rx_gain_db | output | 5 | Receive gain in dB (code x 4) |

## Verification
Two collisions are provoked on purpose. In the first, power-down is asserted in the same clock as a commit of 8'hFF. The outputs must read the defaults and not the shifted word. In the second, `ser_clk` and `ser_en` are raised on the same edge after a complete byte has been shifted. The committed word must be the 8 bits shifted before that edge, 8'h3C, and not a word that includes the extra bit. Both results are judged at the ports, through the decoded outputs.

// File: rtl/spc_pkg.sv
package spc_pkg;
   localparam int CFG_W     = 8;
   localparam int VOL_W     = 3;
   localparam int BIT_TXA   = 7;
   localparam int BIT_TXB   = 6;
   localparam int BIT_DRV   = 5;
   localparam int BIT_AUX   = 4;
   localparam int BIT_SPARE = 3;
   localparam int VOL_MSB   = 2;

   typedef enum logic [1:0] {
      TX_MUTE = 2'b00,
      TX_A    = 2'b01,
      TX_B    = 2'b10,
      TX_SUM  = 2'b11
   } tx_src_e;

   typedef struct packed {
      logic a_on;
      logic b_on;
      logic halve;
   } tx_path_t;

   localparam logic [CFG_W-1:0] CFG_DEFAULT = 8'hA0;
endpackage

// File: rtl/spc_sync.sv
module spc_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("spc_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_badw
         $error("spc_sync: WIDTH must be positive");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk) begin
      chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/spc_shift_hold.sv
module spc_shift_hold #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         clear,
   input  logic         shift_en,
   input  logic         bit_in,
   output logic [W-1:0] word
);
   generate
      if (W < 2) begin : g_bad
         $error("spc_shift_hold: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (clear) begin
         word <= '0;
      end else if (shift_en) begin
         word <= {word[W-2:0], bit_in};
      end
   end
endmodule

// File: rtl/spc_active_reg.sv
module spc_active_reg #(
   parameter int           W       = 8,
   parameter logic [W-1:0] DEFAULT = '0
) (
   input  logic         clk,
   input  logic         force_def,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (force_def) begin
         q <= DEFAULT;
      end else if (load) begin
         q <= d;
      end
   end
endmodule

// File: rtl/spc_path_decode.sv
module spc_path_decode
   import spc_pkg::*;
#(
   parameter int STEP_DB = 4,
   parameter int GAIN_W  = 5
) (
   input  logic [CFG_W-1:0]  word,
   output logic [1:0]        tx_src,
   output logic              tx_a_on,
   output logic              tx_b_on,
   output logic              tx_halve,
   output logic              rx_drv_on,
   output logic              rx_aux_on,
   output logic [VOL_W-1:0]  rx_vol,
   output logic [GAIN_W-1:0] rx_gain_db
);
   localparam int MAX_GAIN = ((1 << VOL_W) - 1) * STEP_DB;
   localparam bit POW2     = (STEP_DB & (STEP_DB - 1)) == 0;

   generate
      if (MAX_GAIN >= (1 << GAIN_W)) begin : g_bad
         $error("spc_path_decode: GAIN_W too narrow for the gain range");
      end
   endgenerate

   tx_src_e  src;
   tx_path_t path;
   logic     unused_spare;

   assign unused_spare = word[BIT_SPARE];
   assign src          = tx_src_e'({word[BIT_TXB], word[BIT_TXA]});

   always_comb begin
      path = '0;
      unique case (src)
         TX_MUTE: path = '0;
         TX_A:    path.a_on = 1'b1;
         TX_B:    path.b_on = 1'b1;
         TX_SUM:  path = '{a_on: 1'b1, b_on: 1'b1, halve: 1'b1};
         default: path = '0;
      endcase
   end

   assign tx_src    = src;
   assign tx_a_on   = path.a_on;
   assign tx_b_on   = path.b_on;
   assign tx_halve  = path.halve;
   assign rx_drv_on = word[BIT_DRV];
   assign rx_aux_on = word[BIT_AUX];
   assign rx_vol    = word[VOL_MSB -: VOL_W];

   generate
      if (POW2) begin : g_shift_gain
         assign rx_gain_db = GAIN_W'(rx_vol) << $clog2(STEP_DB);
      end else begin : g_mult_gain
         assign rx_gain_db = GAIN_W'(int'(rx_vol) * STEP_DB);
      end
   endgenerate
endmodule

// File: rtl/serial_path_ctl.sv
module serial_path_ctl
   import spc_pkg::*;
#(
   parameter int  SYNC_STAGES = 2,
   parameter int  STEP_DB     = 4,
   localparam int GAIN_W      = $clog2(((1 << VOL_W) - 1) * STEP_DB + 1)
) (
   input  logic              clk,
   input  logic              sleep_n,
   input  logic              ser_en,
   input  logic              ser_clk,
   input  logic              ser_dat,
   output logic [1:0]        tx_src,
   output logic              tx_a_on,
   output logic              tx_b_on,
   output logic              tx_halve,
   output logic              rx_drv_on,
   output logic              rx_aux_on,
   output logic [VOL_W-1:0]  rx_vol,
   output logic [GAIN_W-1:0] rx_gain_db
);
   generate
      if (STEP_DB < 1) begin : g_bad_step
         $error("serial_path_ctl: STEP_DB must be positive");
      end
   endgenerate

   logic [2:0]       raw_in, syn_lvl;
   logic             en_lvl, ck_lvl, dat_lvl;
   logic             en_prev, ck_prev;
   logic             en_rise, ck_rise;
   logic             shift_en, commit;
   logic [CFG_W-1:0] hold_word, act_word;

   assign raw_in = {ser_en, ser_clk, ser_dat};

   spc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .din  (raw_in),
      .dout (syn_lvl)
   );

   assign {en_lvl, ck_lvl, dat_lvl} = syn_lvl;

   always_ff @(posedge clk) begin
      en_prev <= en_lvl;
      ck_prev <= ck_lvl;
   end

   assign en_rise  = en_lvl & ~en_prev;
   assign ck_rise  = ck_lvl & ~ck_prev;
   assign shift_en = sleep_n & ck_rise & ~en_lvl;
   assign commit   = sleep_n & en_rise;

   spc_shift_hold #(.W(CFG_W)) u_hold (
      .clk      (clk),
      .clear    (~sleep_n),
      .shift_en (shift_en),
      .bit_in   (dat_lvl),
      .word     (hold_word)
   );

   spc_active_reg #(.W(CFG_W), .DEFAULT(CFG_DEFAULT)) u_active (
      .clk       (clk),
      .force_def (~sleep_n),
      .load      (commit),
      .d         (hold_word),
      .q         (act_word)
   );

   spc_path_decode #(.STEP_DB(STEP_DB), .GAIN_W(GAIN_W)) u_dec (
      .word       (act_word),
      .tx_src     (tx_src),
      .tx_a_on    (tx_a_on),
      .tx_b_on    (tx_b_on),
      .tx_halve   (tx_halve),
      .rx_drv_on  (rx_drv_on),
      .rx_aux_on  (rx_aux_on),
      .rx_vol     (rx_vol),
      .rx_gain_db (rx_gain_db)
   );
endmodule

// File: rtl/serial_path_ctl_chk.sv
module serial_path_ctl_chk #(
   parameter int STEP_DB = 4,
   parameter int GAIN_W  = 5
) (
   input logic              clk,
   input logic              sleep_n,
   input logic              commit,
   input logic              en_lvl,
   input logic [7:0]        hold_word,
   input logic [1:0]        tx_src,
   input logic              tx_a_on,
   input logic              tx_b_on,
   input logic              tx_halve,
   input logic              rx_drv_on,
   input logic              rx_aux_on,
   input logic [2:0]        rx_vol,
   input logic [GAIN_W-1:0] rx_gain_db
);
   logic pd_q;

   always_ff @(posedge clk) begin
      pd_q <= ~sleep_n;
      if (pd_q) begin
         // R7
         pd_default_chk: assert (tx_src == 2'b01 && tx_a_on && !tx_b_on && !tx_halve
                                 && rx_drv_on && !rx_aux_on && rx_vol == 3'd0)
            else $error("pd_default_chk: outputs not at defaults during power-down");
      end
   end

   // R2
   hold_ignore_chk: assert property (@(posedge clk) disable iff (!sleep_n)
      en_lvl |=> $stable(hold_word));

   // R3
   commit_only_chk: assert property (@(posedge clk) disable iff (!sleep_n)
      !commit |=> $stable({tx_src, tx_a_on, tx_b_on, tx_halve, rx_drv_on, rx_aux_on, rx_vol}));

   // R4
   mute_off_chk: assert property (@(posedge clk) disable iff (!sleep_n)
      (tx_src == 2'b00) |-> (!tx_a_on && !tx_b_on && !tx_halve));

   // R4
   halve_both_chk: assert property (@(posedge clk) disable iff (!sleep_n)
      tx_halve |-> (tx_a_on && tx_b_on));

   // R6
   gain_step_chk: assert property (@(posedge clk) disable iff (!sleep_n)
      int'(rx_gain_db) == int'(rx_vol) * STEP_DB);
endmodule

bind serial_path_ctl serial_path_ctl_chk #(.STEP_DB(STEP_DB), .GAIN_W(GAIN_W)) u_chk (
   .clk        (clk),
   .sleep_n    (sleep_n),
   .commit     (commit),
   .en_lvl     (en_lvl),
   .hold_word  (hold_word),
   .tx_src     (tx_src),
   .tx_a_on    (tx_a_on),
   .tx_b_on    (tx_b_on),
   .tx_halve   (tx_halve),
   .rx_drv_on  (rx_drv_on),
   .rx_aux_on  (rx_aux_on),
   .rx_vol     (rx_vol),
   .rx_gain_db (rx_gain_db)
);

// File: tb/tb_serial_path_ctl.sv
`timescale 1ns/1ps
module tb_serial_path_ctl;
   localparam int S   = 2;
   localparam int H   = 4;
   localparam int LAT = S + 2;

   logic       clk = 1'b0;
   logic       sleep_n = 1'b0;
   logic       ser_en = 1'b1;
   logic       ser_clk = 1'b0;
   logic       ser_dat = 1'b0;
   logic [1:0] tx_src;
   logic       tx_a_on, tx_b_on, tx_halve, rx_drv_on, rx_aux_on;
   logic [2:0] rx_vol;
   logic [4:0] rx_gain_db;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   serial_path_ctl #(.SYNC_STAGES(S), .STEP_DB(4)) dut (
      .clk(clk), .sleep_n(sleep_n), .ser_en(ser_en), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .tx_src(tx_src), .tx_a_on(tx_a_on), .tx_b_on(tx_b_on), .tx_halve(tx_halve),
      .rx_drv_on(rx_drv_on), .rx_aux_on(rx_aux_on), .rx_vol(rx_vol), .rx_gain_db(rx_gain_db)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Expected outputs derived from the bit map in the requirements.
   task automatic chk(input string tag, input logic [7:0] w);
      logic [14:0] act, exp;
      act = {tx_src, tx_a_on, tx_b_on, tx_halve, rx_drv_on, rx_aux_on, rx_vol, rx_gain_db};
      exp = {w[6], w[7], w[7], w[6], w[7] & w[6], w[5], w[4], w[2:0], 5'(w[2:0] * 4)};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h (word %h)", tag, act, exp, w);
      end
   endtask

   task automatic shift_bits(input logic [15:0] v, input int n);
      ser_en = 1'b0;
      step(H);
      for (int i = n - 1; i >= 0; i--) begin
         ser_dat = v[i];
         step(H);
         ser_clk = 1'b1;
         step(H);
         ser_clk = 1'b0;
      end
      step(H);
   endtask

   task automatic commit_now();
      ser_en = 1'b1;
      step(LAT);
   endtask

   task automatic write_word(input logic [7:0] w);
      shift_bits({8'h00, w}, 8);
      commit_now();
      step(H);
   endtask

   task automatic t_reset();
      sleep_n = 1'b0;
      step(8);
      sleep_n = 1'b1;
      step(4);
      chk("R7 reset defaults", 8'hA0);
   endtask

   task automatic t_modes();
      logic [7:0] words [9] = '{8'h00, 8'h80, 8'h40, 8'hC0, 8'h20, 8'h10, 8'h05, 8'h07, 8'h08};
      foreach (words[k]) begin
         shift_bits({8'h00, words[k]}, 8);
         commit_now();
         chk("R1 R3 R4 R5 R6 decode", words[k]);
         step(H);
      end
   endtask

   task automatic t_pending();
      write_word(8'h55);
      shift_bits(16'h00AA, 8);
      chk("R3 shift without commit", 8'h55);
      commit_now();
      chk("R3 commit applies", 8'hAA);
      step(H);
   endtask

   task automatic t_ignore();
      write_word(8'h55);
      for (int i = 0; i < 8; i++) begin
         ser_dat = 1'b0;
         step(H);
         ser_clk = 1'b1;
         step(H);
         ser_clk = 1'b0;
      end
      ser_en = 1'b0;
      step(H);
      commit_now();
      chk("R2 clocks ignored while enable high", 8'h55);
      step(H);
   endtask

   task automatic t_long();
      shift_bits(16'h0F21, 12);
      commit_now();
      chk("R1 last eight bits kept", 8'h21);
      step(H);
   endtask

   task automatic t_powerdown();
      write_word(8'hFF);
      chk("R7 pre power-down", 8'hFF);
      sleep_n = 1'b0;
      step(3);
      chk("R7 forced during power-down", 8'hA0);
      sleep_n = 1'b1;
      step(10);
      chk("R7 defaults held after release", 8'hA0);
   endtask

   task automatic t_partial();
      shift_bits(16'h0005, 3);
      commit_now();
      chk("R8 cleared holder partial word", 8'h05);
      step(H);
   endtask

   task automatic t_pd_commit();
      write_word(8'h12);
      shift_bits(16'h00FF, 8);
      sleep_n = 1'b0;
      ser_en = 1'b1;
      step(6);
      sleep_n = 1'b1;
      step(6);
      chk("R9 power-down beats commit", 8'hA0);
   endtask

   task automatic t_same_edge();
      shift_bits(16'h003C, 8);
      ser_dat = 1'b1;
      step(H);
      ser_clk = 1'b1;
      ser_en = 1'b1;
      step(LAT);
      chk("R9 clock rise with enable rise ignored", 8'h3C);
      ser_clk = 1'b0;
      step(H);
   endtask

   initial begin
      step(2);
      t_reset();
      t_modes();
      t_pending();
      t_ignore();
      t_long();
      t_powerdown();
      t_partial();
      t_pd_commit();
      t_same_edge();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule